// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is a 16-bit integer arithmetic and logic unit that computes one operation per issued cycle and keeps its result and a five-bit status word in registers. It adds, subtracts (with or without an incoming borrow), negates, applies bitwise logic and shifts by a variable amount. Every operation can run on the whole word or on the low byte only. In byte mode the flags are formed from the low byte, and the high byte of the result carries operand A through unchanged.

Each opcode writes only some of the status bits. The set written by the most recent issued operation is presented as a mask beside the flags. Bits outside that mask keep their earlier values, so a sequence of operations can combine, for example, an arithmetic carry with a later logic test. On subtraction the carry and digit-carry bits hold the inverse of a borrow, so a chain of subtract-with-borrow operations uses the same carry input as a chain of add-with-carry operations.

Top module: `status_alu`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears result, flags and flag_mask to zero. Flag bit positions: [0] carry, [1] zero, [2] negative, [3] overflow, [4] digit carry.
- R2: Result, flags and flag_mask load on the rising clock edge when issue is high. They keep their values in every cycle in which issue is low.
- R3: Opcodes 0 ADD (A+B), 1 ADDC (A+B+carry_in), 2 SUB (A-B), 3 SUBB (A-B-1+carry_in) and 4 NEG (0-A) give two's complement results. Carry is the carry out of the active top bit, and on subtraction a carry of 1 means no borrow occurred.
- R4: Overflow is set when the two added operands share a sign and the result sign differs from it. For SUB, SUBB and NEG it is set when the minuend and subtrahend signs differ and the result sign differs from the minuend's.
- R5: Digit carry is the carry out of bit 3 into bit 4, in both widths. On subtraction a value of 1 means no borrow from the low nibble.
- R6: Zero tests the active width only (bits 7:0 in byte mode, 15:0 in word mode). Negative copies the active top bit (bit 7 or bit 15).
- R7: With byte_mode high, result[15:8] equals op_a[15:8], and carry and overflow are taken at bit 7.
- R8: Opcodes 5 AND, 6 IOR, 7 XOR, 8 COM (~A) and 9 MOV (A) write only zero and negative (mask 5'b00110).
- R9: Opcodes 10 SHL, 11 LSR and 12 ASR shift A by op_b[3:0] in word mode or op_b[2:0] in byte mode. Carry takes the last bit shifted out, and zero and negative are written (mask 5'b00111). A shift amount of zero leaves carry unchanged (mask 5'b00110). Overflow and digit carry are never written by a shift.
- R10: flag_mask shows the flags written by the last issued operation (arithmetic: 5'b11111). A flag outside that mask keeps its previous value.
- R11: Opcodes 13 to 15 load result with op_a and write no flag (mask 5'b00000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Perform the presented operation this cycle |
| opcode | input | 4 | Operation select |
| byte_mode | input | 1 | 1: low byte operation, 0: full word |
| carry_in | input | 1 | Carry (inverse borrow) used by ADDC and SUBB |
| op_a | input | 16 | First operand, shift source |
| op_b | input | 16 | Second operand, shift amount |
| result | output | 16 | Registered result |
| flags | output | 5 | Registered status bits |
| flag_mask | output | 5 | Flags written by the last issued operation |

## Verification
The bench uses the default parameters: a 16-bit word with an 8-bit byte lane, a 4-bit digit boundary and the staged log-depth shifter. With the lane at bit 8 and the digit boundary at bit 4, each carry source can be reached with small operand values. These include the byte carry at 0x80+0x80 and the digit carry at 0x08+0x08, and the borrow forms of both. The 4-bit and 3-bit shift amount fields make the largest word shift (15) and the byte field wrap (amount 8 read as 0) easy to reach. The table runs operations in sequence, so each expected flag word depends on which bits the previous operations left in place.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBB  = 4'd3,
      OP_NEG   = 4'd4,
      OP_AND   = 4'd5,
      OP_IOR   = 4'd6,
      OP_XOR   = 4'd7,
      OP_COM   = 4'd8,
      OP_MOV   = 4'd9,
      OP_SHL   = 4'd10,
      OP_LSR   = 4'd11,
      OP_ASR   = 4'd12,
      OP_RSV13 = 4'd13,
      OP_RSV14 = 4'd14,
      OP_RSV15 = 4'd15
   } alu_op_e;

   localparam int FLAG_CNT = 5;
   localparam int FL_C  = 0;
   localparam int FL_Z  = 1;
   localparam int FL_N  = 2;
   localparam int FL_OV = 3;
   localparam int FL_DC = 4;

   typedef logic [FLAG_CNT-1:0] flag_vec_t;

   localparam flag_vec_t MASK_ARITH = 5'b11111;
   localparam flag_vec_t MASK_LOGIC = 5'b00110;
   localparam flag_vec_t MASK_SHIFT = 5'b00111;
   localparam flag_vec_t MASK_NONE  = 5'b00000;

   typedef enum logic [1:0] {
      CLS_ARITH = 2'd0,
      CLS_LOGIC = 2'd1,
      CLS_SHIFT = 2'd2,
      CLS_PASS  = 2'd3
   } op_class_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_EXT  = 2'd2
   } cin_sel_e;

   typedef enum logic [1:0] {
      LG_AND  = 2'd0,
      LG_IOR  = 2'd1,
      LG_XOR  = 2'd2,
      LG_PASS = 2'd3
   } logic_fn_e;

   typedef struct packed {
      op_class_e cls;
      logic      neg_a;     // arithmetic on (0, A) instead of (A, B)
      logic      inv_y;     // second adder operand inverted
      cin_sel_e  cin_sel;
      logic_fn_e lfn;
      logic      inv_res;   // logic result inverted
      logic      sh_left;
      logic      sh_arith;
      flag_vec_t mask;
   } alu_ctrl_t;

endpackage

// File: rtl/status_alu_decode.sv
module status_alu_decode
   import status_alu_pkg::*;
(
   input  logic [3:0] opcode,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl.cls      = CLS_PASS;
      ctrl.neg_a    = 1'b0;
      ctrl.inv_y    = 1'b0;
      ctrl.cin_sel  = CIN_ZERO;
      ctrl.lfn      = LG_PASS;
      ctrl.inv_res  = 1'b0;
      ctrl.sh_left  = 1'b0;
      ctrl.sh_arith = 1'b0;
      ctrl.mask     = MASK_NONE;
      case (opcode)
         OP_ADD: begin
            ctrl.cls  = CLS_ARITH;
            ctrl.mask = MASK_ARITH;
         end
         OP_ADDC: begin
            ctrl.cls     = CLS_ARITH;
            ctrl.cin_sel = CIN_EXT;
            ctrl.mask    = MASK_ARITH;
         end
         OP_SUB: begin
            ctrl.cls     = CLS_ARITH;
            ctrl.inv_y   = 1'b1;
            ctrl.cin_sel = CIN_ONE;
            ctrl.mask    = MASK_ARITH;
         end
         OP_SUBB: begin
            ctrl.cls     = CLS_ARITH;
            ctrl.inv_y   = 1'b1;
            ctrl.cin_sel = CIN_EXT;
            ctrl.mask    = MASK_ARITH;
         end
         OP_NEG: begin
            ctrl.cls     = CLS_ARITH;
            ctrl.neg_a   = 1'b1;
            ctrl.inv_y   = 1'b1;
            ctrl.cin_sel = CIN_ONE;
            ctrl.mask    = MASK_ARITH;
         end
         OP_AND: begin
            ctrl.cls  = CLS_LOGIC;
            ctrl.lfn  = LG_AND;
            ctrl.mask = MASK_LOGIC;
         end
         OP_IOR: begin
            ctrl.cls  = CLS_LOGIC;
            ctrl.lfn  = LG_IOR;
            ctrl.mask = MASK_LOGIC;
         end
         OP_XOR: begin
            ctrl.cls  = CLS_LOGIC;
            ctrl.lfn  = LG_XOR;
            ctrl.mask = MASK_LOGIC;
         end
         OP_COM: begin
            ctrl.cls     = CLS_LOGIC;
            ctrl.lfn     = LG_PASS;
            ctrl.inv_res = 1'b1;
            ctrl.mask    = MASK_LOGIC;
         end
         OP_MOV: begin
            ctrl.cls  = CLS_LOGIC;
            ctrl.lfn  = LG_PASS;
            ctrl.mask = MASK_LOGIC;
         end
         OP_SHL: begin
            ctrl.cls     = CLS_SHIFT;
            ctrl.sh_left = 1'b1;
            ctrl.mask    = MASK_SHIFT;
         end
         OP_LSR: begin
            ctrl.cls  = CLS_SHIFT;
            ctrl.mask = MASK_SHIFT;
         end
         OP_ASR: begin
            ctrl.cls      = CLS_SHIFT;
            ctrl.sh_arith = 1'b1;
            ctrl.mask     = MASK_SHIFT;
         end
         default: begin
            ctrl.cls  = CLS_PASS;
            ctrl.mask = MASK_NONE;
         end
      endcase
   end

endmodule

// File: rtl/status_alu_arith.sv
module status_alu_arith
   import status_alu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DIGIT_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              neg_a,
   input  logic              inv_y,
   input  cin_sel_e          cin_sel,
   input  logic              carry_in,
   input  logic              byte_mode,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              ovf,
   output logic              dcarry
);

   localparam int LANE_W = DATA_W / 2;

   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] y;
   logic [DATA_W:0]   full;
   logic              cin;
   logic              lane_cout;
   logic              x_sign;
   logic              y_sign;
   logic              r_sign;

   // operand formation: (A, B) or (0, A), optional inversion of the second
   always_comb begin
      x = neg_a ? '0 : a;
      y = neg_a ? a : b;
      if (inv_y) begin
         y = ~y;
      end
   end

   always_comb begin
      case (cin_sel)
         CIN_ONE: cin = 1'b1;
         CIN_EXT: cin = carry_in;
         default: cin = 1'b0;
      endcase
   end

   // one adder; carries at inner boundaries are recovered from sum bits
   assign full      = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
   assign lane_cout = full[LANE_W] ^ x[LANE_W] ^ y[LANE_W];
   assign dcarry    = full[DIGIT_W] ^ x[DIGIT_W] ^ y[DIGIT_W];
   assign sum       = full[DATA_W-1:0];

   assign carry  = byte_mode ? lane_cout : full[DATA_W];
   assign x_sign = byte_mode ? x[LANE_W-1] : x[DATA_W-1];
   assign y_sign = byte_mode ? y[LANE_W-1] : y[DATA_W-1];
   assign r_sign = byte_mode ? full[LANE_W-1] : full[DATA_W-1];
   assign ovf    = (x_sign == y_sign) && (r_sign != x_sign);

endmodule

// File: rtl/status_alu_shift.sv
module status_alu_shift #(
   parameter int W      = 16,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]         val,
   input  logic [$clog2(W)-1:0] amt,
   input  logic                 left,
   input  logic                 arith,
   output logic [W-1:0]         res,
   output logic                 cout
);

   localparam int AMT_W = $clog2(W);

   // W+1 bit working vector: the extra bit catches the last bit shifted out
   logic [W:0] seed;
   logic [W:0] done;

   assign seed = left ? {1'b0, val} : {val, 1'b0};

   generate
      if (STAGED) begin : g_staged
         logic [W:0] stg [0:AMT_W];
         assign stg[0] = seed;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 2 ** k;
            logic [W:0] moved;
            always_comb begin
               if (left) begin
                  moved = stg[k] << SH;
               end else if (arith) begin
                  moved = $signed(stg[k]) >>> SH;
               end else begin
                  moved = stg[k] >> SH;
               end
            end
            assign stg[k+1] = amt[k] ? moved : stg[k];
         end
         assign done = stg[AMT_W];
      end else begin : g_flat
         always_comb begin
            if (left) begin
               done = seed << amt;
            end else if (arith) begin
               done = $signed(seed) >>> amt;
            end else begin
               done = seed >> amt;
            end
         end
      end
   endgenerate

   assign res  = left ? done[W-1:0] : done[W:1];
   assign cout = left ? done[W] : done[0];

endmodule

// File: rtl/status_alu_flags.sv
module status_alu_flags
   import status_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  op_class_e         cls,
   input  flag_vec_t         base_mask,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] res,
   input  logic              ar_carry,
   input  logic              ar_ovf,
   input  logic              ar_dcarry,
   input  logic              sh_cout,
   input  logic              sh_amt_zero,
   output flag_vec_t         new_flags,
   output flag_vec_t         eff_mask
);

   localparam int LANE_W = DATA_W / 2;

   logic zero_det;
   logic neg_det;

   assign zero_det = byte_mode ? (res[LANE_W-1:0] == '0) : (res == '0);
   assign neg_det  = byte_mode ? res[LANE_W-1] : res[DATA_W-1];

   always_comb begin
      new_flags        = '0;
      new_flags[FL_C]  = (cls == CLS_SHIFT) ? sh_cout : ar_carry;
      new_flags[FL_Z]  = zero_det;
      new_flags[FL_N]  = neg_det;
      new_flags[FL_OV] = ar_ovf;
      new_flags[FL_DC] = ar_dcarry;
   end

   // a shift by nothing shifts nothing out, so carry is not written
   always_comb begin
      eff_mask = base_mask;
      if (cls == CLS_SHIFT && sh_amt_zero) begin
         eff_mask[FL_C] = 1'b0;
      end
   end

endmodule

// File: rtl/status_alu.sv
module status_alu
   import status_alu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int DIGIT_W      = 4,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue,
   input  logic [3:0]          opcode,
   input  logic                byte_mode,
   input  logic                carry_in,
   input  logic [DATA_W-1:0]   op_a,
   input  logic [DATA_W-1:0]   op_b,
   output logic [DATA_W-1:0]   result,
   output logic [FLAG_CNT-1:0] flags,
   output logic [FLAG_CNT-1:0] flag_mask
);

   localparam int LANE_W  = DATA_W / 2;
   localparam int WAMT_W  = $clog2(DATA_W);
   localparam int BAMT_W  = $clog2(LANE_W);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("status_alu: DATA_W must be even and at least 4");
      end
      if (DIGIT_W < 1 || DIGIT_W >= LANE_W) begin : g_bad_digit
         $error("status_alu: DIGIT_W must lie inside the byte lane");
      end
   endgenerate

   alu_ctrl_t ctrl;

   status_alu_decode u_decode (
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   logic [DATA_W-1:0] ar_sum;
   logic              ar_carry;
   logic              ar_ovf;
   logic              ar_dcarry;

   status_alu_arith #(
      .DATA_W  (DATA_W),
      .DIGIT_W (DIGIT_W)
   ) u_arith (
      .a         (op_a),
      .b         (op_b),
      .neg_a     (ctrl.neg_a),
      .inv_y     (ctrl.inv_y),
      .cin_sel   (ctrl.cin_sel),
      .carry_in  (carry_in),
      .byte_mode (byte_mode),
      .sum       (ar_sum),
      .carry     (ar_carry),
      .ovf       (ar_ovf),
      .dcarry    (ar_dcarry)
   );

   logic [DATA_W-1:0] shw_res;
   logic              shw_cout;
   logic [LANE_W-1:0] shb_res;
   logic              shb_cout;

   status_alu_shift #(
      .W      (DATA_W),
      .STAGED (STAGED_SHIFT)
   ) u_shift_word (
      .val   (op_a),
      .amt   (op_b[WAMT_W-1:0]),
      .left  (ctrl.sh_left),
      .arith (ctrl.sh_arith),
      .res   (shw_res),
      .cout  (shw_cout)
   );

   status_alu_shift #(
      .W      (LANE_W),
      .STAGED (STAGED_SHIFT)
   ) u_shift_byte (
      .val   (op_a[LANE_W-1:0]),
      .amt   (op_b[BAMT_W-1:0]),
      .left  (ctrl.sh_left),
      .arith (ctrl.sh_arith),
      .res   (shb_res),
      .cout  (shb_cout)
   );

   logic              sh_cout;
   logic              sh_amt_zero;

   assign sh_cout     = byte_mode ? shb_cout : shw_cout;
   assign sh_amt_zero = byte_mode ? (op_b[BAMT_W-1:0] == '0)
                                  : (op_b[WAMT_W-1:0] == '0);

   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] raw_res;
   logic [LANE_W-1:0] low_res;
   logic [DATA_W-1:0] next_res;

   always_comb begin
      case (ctrl.lfn)
         LG_AND:  logic_res = op_a & op_b;
         LG_IOR:  logic_res = op_a | op_b;
         LG_XOR:  logic_res = op_a ^ op_b;
         default: logic_res = op_a;
      endcase
      if (ctrl.inv_res) begin
         logic_res = ~logic_res;
      end
   end

   always_comb begin
      case (ctrl.cls)
         CLS_ARITH: raw_res = ar_sum;
         CLS_LOGIC: raw_res = logic_res;
         CLS_SHIFT: raw_res = shw_res;
         default:   raw_res = op_a;
      endcase
      low_res  = (ctrl.cls == CLS_SHIFT) ? shb_res : raw_res[LANE_W-1:0];
      next_res = byte_mode ? {op_a[DATA_W-1:LANE_W], low_res} : raw_res;
   end

   flag_vec_t new_flags;
   flag_vec_t eff_mask;

   status_alu_flags #(
      .DATA_W (DATA_W)
   ) u_flags (
      .cls         (ctrl.cls),
      .base_mask   (ctrl.mask),
      .byte_mode   (byte_mode),
      .res         (next_res),
      .ar_carry    (ar_carry),
      .ar_ovf      (ar_ovf),
      .ar_dcarry   (ar_dcarry),
      .sh_cout     (sh_cout),
      .sh_amt_zero (sh_amt_zero),
      .new_flags   (new_flags),
      .eff_mask    (eff_mask)
   );

   flag_vec_t flags_q;
   flag_vec_t mask_q;
   logic [DATA_W-1:0] result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         mask_q   <= '0;
      end else if (issue) begin
         result_q <= next_res;
         mask_q   <= eff_mask;
      end
   end

   generate
      for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags_q[i] <= 1'b0;
            end else if (issue && eff_mask[i]) begin
               flags_q[i] <= new_flags[i];
            end
         end
      end
   endgenerate

   assign result    = result_q;
   assign flags     = flags_q;
   assign flag_mask = mask_q;

endmodule

// File: rtl/status_alu_chk.sv
module status_alu_chk
   import status_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                issue,
   input logic [3:0]          opcode,
   input logic                byte_mode,
   input logic [DATA_W-1:0]   op_a,
   input logic [DATA_W-1:0]   result,
   input logic [FLAG_CNT-1:0] flags,
   input logic [FLAG_CNT-1:0] flag_mask
);

   localparam int LANE_W = DATA_W / 2;

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(result) && $stable(flags) && $stable(flag_mask));

   a_r7_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
      issue && byte_mode |=> result[DATA_W-1:LANE_W] == $past(op_a[DATA_W-1:LANE_W]));

   a_r10_unwritten_keep: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> ((flags ^ $past(flags)) & ~flag_mask) == '0);

   a_r11_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
      issue && (opcode >= 4'd13) |=> (flag_mask == '0) && (result == $past(op_a)));

   a_r6_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !flag_mask[FL_Z] ||
                (flags[FL_Z] == ($past(byte_mode) ? (result[LANE_W-1:0] == '0)
                                                  : (result == '0))));

   a_r6_neg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !flag_mask[FL_N] ||
                (flags[FL_N] == ($past(byte_mode) ? result[LANE_W-1]
                                                  : result[DATA_W-1])));

   a_r8_logic_mask: assert property (@(posedge clk) disable iff (!rst_n)
      issue && (opcode >= 4'd5) && (opcode <= 4'd9) |=> flag_mask == 5'b00110);

   a_r9_shift_keeps_ovdc: assert property (@(posedge clk) disable iff (!rst_n)
      issue && (opcode >= 4'd10) && (opcode <= 4'd12) |=>
         !flag_mask[FL_OV] && !flag_mask[FL_DC] &&
         $stable(flags[FL_OV]) && $stable(flags[FL_DC]));

endmodule

bind status_alu status_alu_chk #(
   .DATA_W (DATA_W)
) u_status_alu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue     (issue),
   .opcode    (opcode),
   .byte_mode (byte_mode),
   .op_a      (op_a),
   .result    (result),
   .flags     (flags),
   .flag_mask (flag_mask)
);

// File: tb/status_alu_bench.sv
`timescale 1ns/1ps
module status_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [3:0]  opcode = '0;
   logic        byte_mode = 1'b0;
   logic        carry_in = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [15:0] result;
   logic [4:0]  flags;
   logic [4:0]  flag_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   status_alu u_status_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .opcode    (opcode),
      .byte_mode (byte_mode),
      .carry_in  (carry_in),
      .op_a      (op_a),
      .op_b      (op_b),
      .result    (result),
      .flags     (flags),
      .flag_mask (flag_mask)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [3:0]  op;
      logic        byt;
      logic        cin;
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] res;
      logic [4:0]  fl;
      logic [4:0]  mk;
   } vec_t;

   localparam int NV = 28;
   // applied in order; expected flags include bits left by earlier rows
   localparam vec_t VT [NV] = '{
      '{4'd3,  4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 5'h1C, 5'h1F}, // R3 R4 add overflow
      '{4'd3,  4'd0,  1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 5'h13, 5'h1F}, // R3 carry, zero
      '{4'd3,  4'd2,  1'b0, 1'b0, 16'h0005, 16'h0007, 16'hFFFE, 5'h04, 5'h1F}, // R3 borrow
      '{4'd4,  4'd2,  1'b0, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 5'h09, 5'h1F}, // R4 sub overflow
      '{4'd8,  4'd5,  1'b0, 1'b0, 16'hF0F0, 16'h0F0F, 16'h0000, 5'h0B, 5'h06}, // R8 AND
      '{4'd8,  4'd6,  1'b0, 1'b0, 16'h8000, 16'h0001, 16'h8001, 5'h0D, 5'h06}, // R8 IOR
      '{4'd8,  4'd7,  1'b0, 1'b0, 16'hFFFF, 16'h00FF, 16'hFF00, 5'h0D, 5'h06}, // R8 XOR
      '{4'd8,  4'd8,  1'b0, 1'b0, 16'h00FF, 16'h1234, 16'hFF00, 5'h0D, 5'h06}, // R8 COM
      '{4'd5,  4'd1,  1'b0, 1'b1, 16'h00FF, 16'h0000, 16'h0100, 5'h10, 5'h1F}, // R5 ADDC digit
      '{4'd3,  4'd3,  1'b0, 1'b0, 16'h0010, 16'h0010, 16'hFFFF, 5'h04, 5'h1F}, // R3 SUBB
      '{4'd7,  4'd0,  1'b1, 1'b0, 16'h127F, 16'h3401, 16'h1280, 5'h1C, 5'h1F}, // R7 byte add
      '{4'd7,  4'd0,  1'b1, 1'b0, 16'hAB80, 16'h0080, 16'hAB00, 5'h0B, 5'h1F}, // R7 byte carry
      '{4'd7,  4'd2,  1'b1, 1'b0, 16'h5500, 16'h1201, 16'h55FF, 5'h04, 5'h1F}, // R7 byte borrow
      '{4'd3,  4'd4,  1'b0, 1'b0, 16'h0001, 16'h0000, 16'hFFFF, 5'h04, 5'h1F}, // R3 NEG
      '{4'd4,  4'd4,  1'b0, 1'b0, 16'h8000, 16'h0000, 16'h8000, 5'h1C, 5'h1F}, // R4 NEG min
      '{4'd3,  4'd4,  1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 5'h13, 5'h1F}, // R3 NEG zero
      '{4'd9,  4'd10, 1'b0, 1'b0, 16'h8001, 16'h0001, 16'h0002, 5'h11, 5'h07}, // R9 SHL
      '{4'd9,  4'd11, 1'b0, 1'b0, 16'h0003, 16'h0001, 16'h0001, 5'h11, 5'h07}, // R9 LSR out 1
      '{4'd9,  4'd11, 1'b0, 1'b0, 16'h0002, 16'h0001, 16'h0001, 5'h10, 5'h07}, // R9 LSR out 0
      '{4'd9,  4'd12, 1'b0, 1'b0, 16'h8000, 16'h0004, 16'hF800, 5'h14, 5'h07}, // R9 ASR
      '{4'd9,  4'd10, 1'b1, 1'b0, 16'h12C1, 16'h0002, 16'h1204, 5'h11, 5'h07}, // R9 byte SHL
      '{4'd9,  4'd11, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 5'h13, 5'h06}, // R9 amount 0
      '{4'd11, 4'd14, 1'b0, 1'b0, 16'hABCD, 16'h1111, 16'hABCD, 5'h13, 5'h00}, // R11 reserved
      '{4'd8,  4'd9,  1'b0, 1'b0, 16'h8000, 16'h0000, 16'h8000, 5'h15, 5'h06}, // R8 MOV
      '{4'd6,  4'd5,  1'b1, 1'b0, 16'hFF00, 16'h00FF, 16'hFF00, 5'h13, 5'h06}, // R6 byte zero
      '{4'd5,  4'd0,  1'b1, 1'b0, 16'h0008, 16'h0008, 16'h0010, 5'h10, 5'h1F}, // R5 byte digit
      '{4'd9,  4'd12, 1'b1, 1'b0, 16'h0081, 16'h0001, 16'h00C0, 5'h15, 5'h07}, // R9 byte ASR
      '{4'd5,  4'd2,  1'b0, 1'b0, 16'h0010, 16'h0001, 16'h000F, 5'h01, 5'h1F}  // R5 digit borrow
   };

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic byt, input logic cin,
                        input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      opcode    = op;
      byte_mode = byt;
      carry_in  = cin;
      op_a      = a;
      op_b      = b;
      issue     = 1'b1;
      @(negedge clk);
      issue     = 1'b0;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "result after reset", result, 16'h0000);
      check("R1", "flags after reset", {11'd0, flags}, 16'h0000);
      check("R1", "mask after reset", {11'd0, flag_mask}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec %0d", VT[i].req, i);
         apply(VT[i].op, VT[i].byt, VT[i].cin, VT[i].a, VT[i].b);
         check(tag, "result", result, VT[i].res);
         check(tag, "flags", {11'd0, flags}, {11'd0, VT[i].fl});
         check(tag, "mask (R10)", {11'd0, flag_mask}, {11'd0, VT[i].mk});
      end

      // R2: inputs change with issue low, nothing moves
      @(negedge clk);
      opcode = 4'd0; byte_mode = 1'b0; op_a = 16'hFFFF; op_b = 16'h0001;
      repeat (2) @(negedge clk);
      check("R2", "held result", result, 16'h000F);
      check("R2", "held flags", {11'd0, flags}, 16'h0001);
      check("R2", "held mask", {11'd0, flag_mask}, 16'h001F);

      // R9: largest word shift, carry from bit 1
      apply(4'd10, 1'b0, 1'b0, 16'h0003, 16'h000F);
      check("R9", "SHL by 15 result", result, 16'h8000);
      check("R9", "SHL by 15 flags", {11'd0, flags}, 16'h0005);

      // R9: byte amount field is 3 bits, so 8 means no shift and carry kept
      apply(4'd11, 1'b1, 1'b0, 16'h3480, 16'h0008);
      check("R9", "byte LSR amount 8 result", result, 16'h3480);
      check("R9", "byte LSR amount 8 flags", {11'd0, flags}, 16'h0005);
      check("R9", "byte LSR amount 8 mask", {11'd0, flag_mask}, 16'h0006);

      // R3: SUBB with carry_in high acts as plain subtract
      apply(4'd3, 1'b0, 1'b1, 16'h0009, 16'h0009);
      check("R3", "SUBB no borrow result", result, 16'h0000);
      check("R3", "SUBB no borrow flags", {11'd0, flags}, 16'h0013);

      // R1: reset in mid run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "result after second reset", result, 16'h0000);
      check("R1", "flags after second reset", {11'd0, flags}, 16'h0000);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

endmodule